// File: doc/BRIEF.md
# Significance-Driven Approximate Multiplier

This block is an unsigned N×N multiplier that gives up a little accuracy to get a much shorter summation tree. Every partial-product bit `a[x] & b[y]` is formed first, as in an exact multiplier. The rows of the multiplier operand are then taken in groups of DEPTH consecutive rows. Inside each group, the bits that share a weight are OR-merged over a run of low-order columns. Each later group merges one column fewer than the group before it. Bits outside every merge run are kept exact and moved, by weight, into the positions that merging left empty. The reduced matrix is then added with exact carry-propagate adders. With DEPTH = 2 the result has N/2 rows.

An OR merge is wrong only when two or more of its inputs are 1. Then the value at that weight is too small, so the product can only fall short of the true value and never exceeds it. Most of the lost value sits in low-significance columns, which keeps the relative error small. The block is intended for datapaths that tolerate imprecision, such as filters and image kernels.

The output can be registered (one cycle of latency, synchronous active-high reset) or purely combinational. The choice is made by a parameter.

Top module: `sdm_approx_mul`

## Requirements
- R1: `p_o` equals the exact product when `a_i` is 0, when `b_i` is 0, or when every DEPTH-bit group of `b_i` holds at most one set bit. The groups are aligned from bit 0: bits [DEPTH·g+DEPTH−1 : DEPTH·g].
- R2: With DEPTH = 2, group g (0-based) merges `a[j]&b[2g] | a[j−1]&b[2g+1]` at weight 2g+j, for j = 1 to N−1−g. The term `a[0]&b[2g]` is kept alone at weight 2g. Every other partial-product bit is added exactly at its natural weight x+y.
- R3: `p_o` is never greater than `a_i·b_i`, for every operand pair and every DEPTH.
- R4: With N = 8 and DEPTH = 2, every inexact result has a shortfall below one third of the exact product, over all 65536 operand pairs.
- R5: With N = 4 and DEPTH = 2, exactly 50 of the 256 operand pairs give an inexact product.
- R6: For a general DEPTH, group g covers `b` rows DEPTH·g to DEPTH·g+DEPTH−1. It merges, at weight DEPTH·g+j for j = 0 to N−1−g, the terms `a[j−d]&b[DEPTH·g+d]` for every d ≤ j. All bits outside these merges are added exactly.
- R7: With OUT_REG = 1, `p_o` shows the product of the operands sampled at the previous rising edge of `clk`. A cycle with `rst` high clears `p_o` to 0 at that edge, whatever the operands are. Normal products resume at the first edge after `rst` falls.
- R8: With OUT_REG = 0, `p_o` follows the operands combinationally within the same cycle, with the same function as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier; its rows are grouped DEPTH at a time |
| p_o | output | 2N | Approximate product |

## Verification
Two behaviours can fall in the same cycle. The first is an OR merge that loses value while the exact carry chain ripples through the same columns. All-ones operands and the exhaustive sweep provoke this. The result is judged against an arithmetic model that subtracts (ones−1)·2^weight for each merge from the true product. The second is a synchronous reset in a cycle whose operands would produce a large product. The bench presents 0xFF×0xFF, raises reset, and requires zero at the next edge. After reset falls, it requires the model's product one edge later.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Legal sizes: N must be a power of two.
  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Highest merge column offset for row group g.
  function automatic int last_col(input int n, input int g);
    return n - 1 - g;
  endfunction

  // True when reduced-matrix row r holds a merged bit at weight w.
  function automatic bit in_cluster(input int n, input int dep, input int r, input int w);
    if (r >= n / dep) return 1'b0;
    return (w >= dep * r) && (w <= dep * r + last_col(n, r));
  endfunction

  // True when partial product a[x]&b[y] is absorbed by an OR merge.
  function automatic bit merged(input int n, input int dep, input int x, input int y);
    return (x + (y % dep)) <= last_col(n, y / dep);
  endfunction

  // Number of exact (unmerged) bits at weight w.
  function automatic int spill_count(input int n, input int dep, input int w);
    int cnt;
    cnt = 0;
    for (int y = 0; y < n; y++) begin
      if ((w - y) >= 0 && (w - y) < n && !merged(n, dep, w - y, y)) cnt++;
    end
    return cnt;
  endfunction

  // Flat index y*n+x of the k-th exact bit at weight w, or -1.
  function automatic int spill_src(input int n, input int dep, input int w, input int k);
    int cnt;
    cnt = 0;
    for (int y = 0; y < n; y++) begin
      if ((w - y) >= 0 && (w - y) < n && !merged(n, dep, w - y, y)) begin
        if (cnt == k) return y * n + (w - y);
        cnt++;
      end
    end
    return -1;
  endfunction

  // Rows needed so that every column fits after remapping.
  function automatic int row_count(input int n, input int dep);
    int best;
    best = n / dep;
    for (int w = 0; w < 2 * n; w++) begin
      int used;
      used = spill_count(n, dep, w);
      for (int r = 0; r < n / dep; r++) begin
        if (in_cluster(n, dep, r, w)) used++;
      end
      if (used > best) best = used;
    end
    return best;
  endfunction

  // Source of slot (r,w): -1 merged bit, >=0 exact bit index, -2 empty.
  function automatic int slot_src(input int n, input int dep, input int r, input int w);
    int k;
    int s;
    if (in_cluster(n, dep, r, w)) return -1;
    k = 0;
    for (int rr = 0; rr < r; rr++) begin
      if (!in_cluster(n, dep, rr, w)) k++;
    end
    s = spill_src(n, dep, w, k);
    return (s < 0) ? -2 : s;
  endfunction

endpackage

// File: rtl/sdm_pp_gen.sv
module sdm_pp_gen #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [N*N-1:0] pp_o
);

  // Full AND array, bit y*N+x carries weight x+y.
  for (genvar y = 0; y < N; y++) begin : g_row
    for (genvar x = 0; x < N; x++) begin : g_col
      assign pp_o[y*N+x] = a_i[x] & b_i[y];
    end
  end

endmodule

// File: rtl/sdm_reduce.sv
module sdm_reduce
  import sdm_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 2,
  parameter int ROWS  = 4
) (
  input  logic [N*N-1:0]      pp_i,
  output logic [ROWS*2*N-1:0] mat_o
);

  localparam int PW  = 2 * N;
  localparam int GRP = N / DEPTH;

  logic [GRP*PW-1:0] clu;

  // Significance-driven merge: group g ORs DEPTH aligned bits per column.
  for (genvar g = 0; g < GRP; g++) begin : g_grp
    for (genvar w = 0; w < PW; w++) begin : g_w
      if (in_cluster(N, DEPTH, g, w)) begin : g_on
        localparam int J = w - DEPTH * g;
        logic [DEPTH-1:0] terms;
        for (genvar d = 0; d < DEPTH; d++) begin : g_d
          if (J >= d) begin : g_t
            assign terms[d] = pp_i[(DEPTH*g+d)*N + (J-d)];
          end else begin : g_z
            assign terms[d] = 1'b0;
          end
        end
        assign clu[g*PW+w] = |terms;
      end else begin : g_off
        assign clu[g*PW+w] = 1'b0;
      end
    end
  end

  // Commutative remap: exact bits fill free slots of equal weight.
  for (genvar r = 0; r < ROWS; r++) begin : g_mr
    for (genvar w = 0; w < PW; w++) begin : g_mw
      localparam int SRC = slot_src(N, DEPTH, r, w);
      if (r < GRP) begin : g_c
        if (SRC >= 0) begin : g_mix
          assign mat_o[r*PW+w] = clu[r*PW+w] | pp_i[SRC];
        end else begin : g_clu
          assign mat_o[r*PW+w] = clu[r*PW+w];
        end
      end else begin : g_x
        if (SRC >= 0) begin : g_raw
          assign mat_o[r*PW+w] = pp_i[SRC];
        end else begin : g_nil
          assign mat_o[r*PW+w] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sdm_row_sum.sv
module sdm_row_sum #(
  parameter int N    = 8,
  parameter int ROWS = 4
) (
  input  logic [ROWS*2*N-1:0] mat_i,
  output logic [2*N-1:0]      sum_o
);

  localparam int PW = 2 * N;

  logic [PW-1:0] acc [ROWS+1];

  assign acc[0] = '0;

  // Exact carry-propagate accumulation, one adder per reduced row.
  for (genvar r = 0; r < ROWS; r++) begin : g_add
    assign acc[r+1] = acc[r] + mat_i[r*PW +: PW];
  end

  assign sum_o = acc[ROWS];

endmodule

// File: rtl/sdm_approx_mul.sv
module sdm_approx_mul
  import sdm_pkg::*;
#(
  parameter int N       = 8,
  parameter int DEPTH   = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [2*N-1:0] p_o
);

  localparam int PW   = 2 * N;
  localparam int GRP  = N / DEPTH;
  localparam int ROWS = row_count(N, DEPTH);
  localparam int EW   = PW + 2;

  if (!is_pow2(N) || DEPTH < 2 || (N % DEPTH) != 0) begin : g_bad_cfg
    $error("sdm_approx_mul: N must be a power of two divisible by DEPTH >= 2");
  end

  logic [N*N-1:0]   pp;
  logic [ROWS*PW-1:0] mat;
  logic [PW-1:0]    sum_w;

  sdm_pp_gen #(.N(N)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  sdm_reduce #(.N(N), .DEPTH(DEPTH), .ROWS(ROWS)) u_red (
    .pp_i  (pp),
    .mat_o (mat)
  );

  sdm_row_sum #(.N(N), .ROWS(ROWS)) u_sum (
    .mat_i (mat),
    .sum_o (sum_w)
  );

  // Checking aids: true product and per-group sparsity of b_i.
  logic [PW-1:0]  exact_w;
  logic [GRP-1:0] grp_light;
  logic           sparse_w;

  assign exact_w = PW'(a_i) * PW'(b_i);
  for (genvar g = 0; g < GRP; g++) begin : g_light
    assign grp_light[g] = ($countones(b_i[DEPTH*g +: DEPTH]) <= 1);
  end
  assign sparse_w = (a_i == '0) || (b_i == '0) || (&grp_light);

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] p_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else     p_q <= sum_w;
    end

    always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q == 1'b1) begin
        p_reset_clear_r7: assert (p_o == '0)
          else $error("R7: output not cleared after reset");
      end
    end

    assign p_o = p_q;

    p_sparse_exact_r1: assert property (@(posedge clk) disable iff (rst)
      sparse_w |=> p_o == $past(exact_w));

    p_never_over_r3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> p_o <= $past(exact_w));

    if (DEPTH == 2) begin : g_rel
      p_rel_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (p_o == $past(exact_w)) ||
                 ((EW'(3) * (EW'($past(exact_w)) - EW'(p_o))) < EW'($past(exact_w))));
    end
  end else begin : g_comb
    assign p_o = sum_w;

    p_sparse_exact_r1: assert property (@(posedge clk) disable iff (rst)
      sparse_w |-> p_o == exact_w);

    p_never_over_r3: assert property (@(posedge clk) disable iff (rst)
      !rst |-> p_o <= exact_w);

    if (DEPTH == 2) begin : g_rel
      p_rel_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |-> (p_o == exact_w) ||
                 ((EW'(3) * (EW'(exact_w) - EW'(p_o))) < EW'(exact_w)));
    end
  end

endmodule

// File: tb/sdm_approx_mul_tb.sv
module sdm_approx_mul_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [7:0]  a8, b8;
  logic [15:0] p8, p8d4;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sdm_approx_mul #(.N(8), .DEPTH(2), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a_i(a8), .b_i(b8), .p_o(p8));

  sdm_approx_mul #(.N(8), .DEPTH(4), .OUT_REG(1'b1)) u_dut_d4 (
    .clk(clk), .rst(rst), .a_i(a8), .b_i(b8), .p_o(p8d4));

  sdm_approx_mul #(.N(4), .DEPTH(2), .OUT_REG(1'b0)) u_dut_n4 (
    .clk(clk), .rst(rst), .a_i(a4), .b_i(b4), .p_o(p4));

  // Arithmetic model: true product minus (ones-1)*2^weight per OR merge.
  function automatic longint model(input int n, input int dep, input longint a, input longint b);
    longint lost;
    lost = 0;
    for (int g = 0; g < n / dep; g++) begin
      for (int j = 0; j <= n - 1 - g; j++) begin
        int ones;
        ones = 0;
        for (int d = 0; d < dep; d++) begin
          if (j >= d) ones += int'(((a >> (j - d)) & (b >> (dep * g + d))) & 64'd1);
        end
        if (ones > 1) lost += longint'(ones - 1) << (dep * g + j);
      end
    end
    return a * b - lost;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec8(input longint pa, input longint pb, inout int miss);
    longint exact;
    longint want;
    bit     sparse;
    exact = pa * pb;
    want  = model(8, 2, pa, pb);
    chk(p8 == want, "R2 depth-2 merge rule", p8, want);
    chk(longint'(p8) <= exact, "R3 never above exact", p8, exact);
    chk((longint'(p8) == exact) || (3 * (exact - longint'(p8)) < exact),
        "R4 shortfall below one third", p8, exact);
    if (longint'(p8) != exact) miss++;
    sparse = (pa == 0) || (pb == 0);
    if (!sparse) begin
      sparse = 1'b1;
      for (int g = 0; g < 4; g++) if (((pb >> (2 * g)) & 3) == 3) sparse = 1'b0;
    end
    if (sparse) chk(longint'(p8) == exact, "R1 sparse operands exact", p8, exact);
    want = model(8, 4, pa, pb);
    chk(p8d4 == want, "R6 depth-4 merge rule", p8d4, want);
    chk(longint'(p8d4) <= exact, "R3 depth-4 never above exact", p8d4, exact);
  endtask

  initial begin
    longint pa, pb;
    bit     have;
    int     miss8, miss4;
    have  = 1'b0;
    miss8 = 0;
    miss4 = 0;
    pa = 0;
    pb = 0;
    rst = 1'b1;
    a8 = 8'hFF;
    b8 = 8'hFF;
    a4 = 4'h0;
    b4 = 4'h0;

    repeat (3) @(negedge clk);
    chk(p8 == 16'h0, "R7 reset state", p8, 0);
    chk(p8d4 == 16'h0, "R7 reset state depth-4", p8d4, 0);
    rst = 1'b0;

    // Exhaustive registered sweep, one operand pair per cycle.
    for (int idx = 0; idx <= 65536; idx++) begin
      @(negedge clk);
      if (have) check_vec8(pa, pb, miss8);
      if (idx < 65536) begin
        a8 = 8'(idx >> 8);
        b8 = 8'(idx);
        pa = longint'(idx >> 8);
        pb = longint'(idx & 255);
        have = 1'b1;
      end
    end
    $display("info: N=8 depth-2 inexact results %0d of 65536", miss8);

    // Reset landing on a cycle with large operands.
    a8 = 8'hFF;
    b8 = 8'hFF;
    @(negedge clk);
    chk(p8 == model(8, 2, 255, 255), "R7 product before reset", p8, model(8, 2, 255, 255));
    rst = 1'b1;
    @(negedge clk);
    chk(p8 == 16'h0, "R7 reset wins over operands", p8, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(p8 == model(8, 2, 255, 255), "R7 resumes after reset", p8, model(8, 2, 255, 255));

    // Combinational N=4 sweep: inputs change mid-cycle, checked 1 ns later.
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        @(posedge clk);
        #2;
        a4 = 4'(ai);
        b4 = 4'(bi);
        #1;
        chk(p4 == model(4, 2, ai, bi), "R8 combinational product", p4, model(4, 2, ai, bi));
        chk(int'(p4) <= ai * bi, "R3 N=4 never above exact", p4, ai * bi);
        if (int'(p4) != ai * bi) miss4++;
      end
    end
    chk(miss4 == 50, "R5 N=4 inexact count", miss4, 50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule